// File: doc/BRIEF.md
# Size-Encoding Base Address Register

This block holds one 32-bit base address for a device's decode window in configuration space. The window is a power of two in size, set by a parameter, and is aligned to its own size. Only the address bits at and above the window size can be written. Every address bit below them is tied to zero. So if software writes all ones and reads the register back, it gets a run of ones from the top down. The lowest one in that run gives the window size. For example, a 1 MB memory window keeps exactly the top 12 bits.

The least significant bits are read-only flags. For a memory window, bit 0 is 0, bits 2:1 give the decoder kind and bit 3 marks the window as prefetchable. For an I/O window, bit 0 is 1 and bit 1 is 0. The register also compares a bus address with the stored base, using only the implemented bits, and raises a registered hit flag when they match and the window is enabled.

Top module: `sizable_bar`

## Requirements
- R1: After reset, every writable bit is 0. The first read returns only the flag field: 0x0000000A for the default memory window, with prefetchable set and kind 01.
- R2: A write changes only bits WIN_LOG2 and above. Writing 0xFFFFFFFF to the default 1 MB window reads back 0xFFF0000A.
- R3: Lane i of `wr_be` (bits 8i+7:8i) gates its byte. A byte whose enable is 0 keeps its old value.
- R4: In a memory window, bit 0 reads 0, bits 2:1 read MEM_KIND and bit 3 reads PREFETCH. No write changes these bits.
- R5: In an I/O window, bit 0 reads 1 and bit 1 reads 0. No write changes these bits. A 256-byte I/O window that is written with all ones reads back 0xFFFFFF01.
- R6: `rd_data` shows the stored value one cycle after `rd_en` is high. If a write arrives in the same cycle, the read returns the value from before that write. While `rd_en` is low, `rd_data` holds its value.
- R7: `hit` goes high one cycle after a cycle in which `win_en` is 1 and `bus_addr`, masked to the implemented bits, equals the stored base. The compare uses the base from before any write in that same cycle.
- R8: `hit` is low one cycle after any cycle in which `win_en` is 0, whatever the address.
- R9: Bits between the flag field and WIN_LOG2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered readback |
| bus_addr | input | 32 | Address to decode |
| win_en | input | 1 | Window decode enable |
| hit | output | 1 | Registered address hit |

## Verification
Both results are due one clock edge after the cycle that causes them. `rd_data` follows a read strobe, and `hit` follows an address and enable. The bench drives inputs on the falling edge. Right after the rising edge it works out the expected values from its model, which still holds the base from before the edge, and only then applies that cycle's write to the model. It compares on the next falling edge. The same stimulus goes to a memory instance and to an I/O instance, so the masking and flag rules for both types are checked against the one stream of inputs.

// File: rtl/sizable_bar_pkg.sv
package sizable_bar_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  function automatic logic [DATA_W-1:0] impl_mask(input int log2);
    impl_mask = '1;
    impl_mask = impl_mask << log2;
  endfunction

  function automatic logic [DATA_W-1:0] flag_field(input bit is_io,
                                                   input logic [1:0] kind,
                                                   input bit pref);
    flag_field = '0;
    if (is_io) flag_field[1:0] = 2'b01;
    else       flag_field[3:0] = {pref, kind, 1'b0};
  endfunction
endpackage

// File: rtl/bar_store.sv
module bar_store
  import sizable_bar_pkg::*;
#(
  parameter int WIN_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] base_q
);
  localparam logic [DATA_W-1:0] MASK = impl_mask(WIN_LOG2);

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        base_q[b*8 +: 8] <= '0;
      else if (wr_en && wr_be[b])
        base_q[b*8 +: 8] <= wr_data[b*8 +: 8] & MASK[b*8 +: 8];
    end
  end
endmodule

// File: rtl/bar_readback.sv
module bar_readback
  import sizable_bar_pkg::*;
#(
  parameter bit         IS_IO    = 1'b0,
  parameter logic [1:0] MEM_KIND = 2'b01,
  parameter bit         PREFETCH = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] FLAGS = flag_field(IS_IO, MEM_KIND, PREFETCH);

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= FLAGS;
    else if (rd_en) rd_data <= base_q | FLAGS;
  end
endmodule

// File: rtl/bar_decode.sv
module bar_decode
  import sizable_bar_pkg::*;
#(
  parameter int WIN_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_en,
  input  logic [DATA_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] base_q,
  output logic              hit
);
  localparam logic [DATA_W-1:0] MASK = impl_mask(WIN_LOG2);

  logic match;
  assign match = ((bus_addr & MASK) == base_q);

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= win_en && match;
  end
endmodule

// File: rtl/sizable_bar.sv
module sizable_bar
  import sizable_bar_pkg::*;
#(
  parameter int         WIN_LOG2 = 20,
  parameter bit         IS_IO    = 1'b0,
  parameter logic [1:0] MEM_KIND = 2'b01,
  parameter bit         PREFETCH = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  input  logic [31:0] bus_addr,
  input  logic        win_en,
  output logic        hit
);
  localparam int FLAG_W = IS_IO ? 2 : 4;

  initial begin
    if (WIN_LOG2 < FLAG_W || WIN_LOG2 >= DATA_W)
      $error("WIN_LOG2 out of range");
  end

  logic [DATA_W-1:0] base_q;

  bar_store #(.WIN_LOG2(WIN_LOG2)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .base_q(base_q)
  );

  bar_readback #(.IS_IO(IS_IO), .MEM_KIND(MEM_KIND), .PREFETCH(PREFETCH)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .base_q(base_q), .rd_data(rd_data)
  );

  bar_decode #(.WIN_LOG2(WIN_LOG2)) u_dec (
    .clk(clk), .rst(rst), .win_en(win_en), .bus_addr(bus_addr),
    .base_q(base_q), .hit(hit)
  );
endmodule

// File: rtl/sizable_bar_chk.sv
module sizable_bar_chk
  import sizable_bar_pkg::*;
#(
  parameter int         WIN_LOG2 = 20,
  parameter bit         IS_IO    = 1'b0,
  parameter logic [1:0] MEM_KIND = 2'b01,
  parameter bit         PREFETCH = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  wr_be,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic [31:0] bus_addr,
  input logic        win_en,
  input logic        hit,
  input logic [31:0] base_q
);
  localparam logic [31:0] MASK  = impl_mask(WIN_LOG2);
  localparam logic [31:0] FLAGS = flag_field(IS_IO, MEM_KIND, PREFETCH);

  // R9
  zero_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~(MASK | FLAGS)) == 32'h0 && (base_q & ~MASK) == 32'h0);

  // R4 R5
  flags_const_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~MASK) == FLAGS);

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R8
  hit_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !win_en |=> !hit);

  // R7
  hit_match_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past((bus_addr & MASK) == base_q));

  // R3
  for (genvar b = 0; b < 4; b++) begin : g_be
    lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_be[b]) |=> $stable(base_q[b*8 +: 8]));
  end
endmodule

bind sizable_bar sizable_bar_chk #(
  .WIN_LOG2(WIN_LOG2), .IS_IO(IS_IO), .MEM_KIND(MEM_KIND), .PREFETCH(PREFETCH)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .rd_en(rd_en),
  .rd_data(rd_data), .bus_addr(bus_addr), .win_en(win_en), .hit(hit),
  .base_q(base_q)
);

// File: tb/sim_sizable_bar.sv
`timescale 1ns/1ps
module sim_sizable_bar;
  localparam int LOG_M = 20;
  localparam int LOG_I = 8;
  localparam logic [31:0] FL_M = 32'h0000000A; // prefetch=1, kind=01, bit0=0
  localparam logic [31:0] FL_I = 32'h00000001; // bit0=1, bit1=0

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, wr_en, rd_en, win_en;
  logic [3:0] wr_be;
  logic [31:0] wr_data, bus_addr;
  logic [31:0] rd_m, rd_i;
  logic hit_m, hit_i;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [31:0] mb_m = 0, mb_i = 0;
  logic [31:0] e_rd_m = FL_M, e_rd_i = FL_I;
  logic e_hit_m = 0, e_hit_i = 0;

  sizable_bar #(.WIN_LOG2(LOG_M), .IS_IO(1'b0), .MEM_KIND(2'b01), .PREFETCH(1'b1)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_m), .bus_addr(bus_addr), .win_en(win_en), .hit(hit_m));

  sizable_bar #(.WIN_LOG2(LOG_I), .IS_IO(1'b1), .MEM_KIND(2'b00), .PREFETCH(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_i), .bus_addr(bus_addr), .win_en(win_en), .hit(hit_i));

  function automatic logic [31:0] msk(input int lg);
    return 32'hFFFFFFFF << lg;
  endfunction

  function automatic logic [31:0] apply_wr(input logic [31:0] old, input logic [31:0] d,
                                           input logic [3:0] be, input int lg);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[b*8 +: 8] = d[b*8 +: 8] & msk(lg)[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // one cycle: inputs applied at negedge, model at posedge, compare next negedge
  task automatic step(input logic w, input logic [3:0] be, input logic [31:0] d,
                      input logic r, input logic [31:0] a, input logic en);
    wr_en = w; wr_be = be; wr_data = d; rd_en = r; bus_addr = a; win_en = en;
    @(posedge clk);
    if (r) begin e_rd_m = mb_m | FL_M; e_rd_i = mb_i | FL_I; end
    e_hit_m = en && ((a & msk(LOG_M)) == mb_m);
    e_hit_i = en && ((a & msk(LOG_I)) == mb_i);
    if (w) begin
      mb_m = apply_wr(mb_m, d, be, LOG_M);
      mb_i = apply_wr(mb_i, d, be, LOG_I);
    end
    @(negedge clk);
    check("R6/R2/R3/R4 mem rd", rd_m, e_rd_m);
    check("R6/R2/R3/R5 io rd", rd_i, e_rd_i);
    check(en ? "R7 mem hit" : "R8 mem hit", {31'b0, hit_m}, {31'b0, e_hit_m});
    check(en ? "R7 io hit" : "R8 io hit", {31'b0, hit_i}, {31'b0, e_hit_i});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd12345));
    rst = 1; wr_en = 0; rd_en = 0; win_en = 0; wr_be = 0; wr_data = 0; bus_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset readback is flags only
    check("R1 mem reset", rd_m, 32'h0000000A);
    check("R1 io reset", rd_i, 32'h00000001);
    step(0, 4'h0, 0, 1, 0, 0);
    check("R1 mem first read", rd_m, 32'h0000000A);
    // R2 R5: all-ones sizing
    step(1, 4'hF, 32'hFFFFFFFF, 0, 0, 0);
    step(0, 4'h0, 0, 1, 0, 0);
    check("R2 mem sizing", rd_m, 32'hFFF0000A);
    check("R5 io sizing", rd_i, 32'hFFFFFF01);
    // R6: same-cycle read sees the old value
    step(1, 4'hF, 32'h12345678, 1, 0, 0);
    check("R6 read before write", rd_m, 32'hFFF0000A);
    step(0, 4'h0, 0, 1, 0, 0);
    check("R2 mem masked write", rd_m, 32'h1230000A);
    // R3: upper byte only
    step(1, 4'h8, 32'hABFFFFFF, 1, 0, 0);
    step(0, 4'h0, 0, 1, 0, 0);
    check("R3 byte lane", rd_m, 32'hAB30000A);
    // R7/R8 directed: edges of window
    step(0, 4'h0, 0, 0, 32'hAB3FFFFF, 1);
    step(0, 4'h0, 0, 0, 32'hAB400000, 1);
    step(0, 4'h0, 0, 0, 32'hAB300000, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [31:0] rv;
      rv = $urandom;
      a = $urandom;
      if (rv[0]) a = (rv[1] ? mb_m : mb_i) | ($urandom & 32'h000FFFFF);
      step(rv[4:2] == 0, rv[11:8], $urandom, rv[5], a, rv[6] | rv[7]);
    end
    finish_run();
  end
endmodule